// File: doc/BRIEF.md
# Four-Character Sixteen-Segment Display Controller

This block is the digital core of a four-character alphanumeric display. Each character has sixteen segments and a decimal point. A host writes characters over a simple parallel bus: seven data bits, a two-bit character address, two active-low chip selects, an active-low write strobe and a store-select line. The store-select line chooses between the character memory and a one-bit-per-character cursor memory. All bus inputs are synchronised to the system clock. One write is committed on the cycle in which the combined enable condition becomes true.

A prescaler sets how many clocks each character stays lit. A two-bit scan counter then visits the four characters in turn. For the visited character, the stored code is decoded through a 64-entry glyph function, or it is replaced by the all-on cursor glyph. The result is registered onto 17 segment outputs and one of four character enables. An active-low blank input darkens the outputs and holds the scan at character 0. An active-low clear input wipes the character memory one scanned character at a time.

Top module: `alnum_disp_ctrl`

## Requirements
- R1: When `cs1_n`, `cs2_n` and `wr_n` are all low and `store_sel` is high, the 7-bit `data_in` is stored in the character word at `dig_addr`. One store happens per activation of that combined condition: a change of `data_in` while the condition stays active is not stored.
- R2: A write strobe with either chip select high, or chip selects low with `wr_n` held high, leaves every stored word unchanged.
- R3: With the write condition active and `store_sel` low, `data_in[0]` is stored as the cursor bit of the addressed character (1 sets, 0 removes). The character word at that address is unchanged.
- R4: `dig_en[k]` lights word address k (address 0 is the rightmost character). Characters are lit in the order 0,1,2,3, repeating, each for `DWELL_CYCLES` clocks. At most one `dig_en` bit is ever high.
- R5: A stored code whose bit 6 equals bit 5 shows all 17 segments off.
- R6: `seg_out[16]` is the decimal point and `seg_out[15:0]` the sixteen segments. No character lights the decimal point. Exact values: space 0x20 gives 0x00000, '0' (0x30) gives 0x030FF, '8' (0x38) gives 0x003FF, '*' (0x2A) gives 0x0FF00, 'A' (0x41) gives 0x003CF, '_' (0x5F) gives 0x00030. A given code always shows the same pattern.
- R7: With `cursor_on` high, a character whose cursor bit is set shows 0x1FFFF. With `cursor_on` low, the stored character shows whatever the cursor bits are. `cursor_on` never alters stored state.
- R8: While `blank_n` is low, `dig_en` and `seg_out` are zero. Both memories keep their contents, and writes are still accepted.
- R9: After `blank_n` returns high, the first character enabled is `dig_en` = 4'b0001.
- R10: Holding `clear_n` low with `blank_n` high for at least 4×`DWELL_CYCLES` clocks sets every character word to zero, whatever the chip selects do. Cursor bits are kept, and cursor writes made during the clear take effect.
- R11: While `blank_n` is low, `clear_n` has no effect on the character memory.
- R12: During and after reset, both memories are zero and the outputs are zero. The first scan after reset shows four dark characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 7 | Character code, or cursor value in bit 0 |
| dig_addr | input | 2 | Character address, 0 = rightmost |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2_n | input | 1 | Chip select 2, active low |
| wr_n | input | 1 | Write strobe, active low |
| store_sel | input | 1 | 1 = character memory, 0 = cursor memory |
| cursor_on | input | 1 | Show the cursor glyph where the cursor bit is set |
| blank_n | input | 1 | Active-low blank, also restarts the scan |
| clear_n | input | 1 | Active-low clear of the character memory |
| seg_out | output | 17 | Segments [15:0] and decimal point [16], active high |
| dig_en | output | 4 | Character enables, active high, one at a time |

## Verification
The hardest case to reach from the ports is a wipe that covers every character. The clear only zeroes the word under the scan, so a clear is complete only if it overlaps a full scan, and it must also carry cursor writes made while it is active. The stimulus therefore holds the clear across more than four dwell periods, with the chip selects low and a cursor write in the middle. It then repeats the clear under blank to show that it is inhibited. Seeded random writes, using mixed chip-select states and both stores, run between full-scan captures. Each capture is compared with a bench model of both memories and a learned glyph map.

// File: rtl/alnum_pkg.sv
package alnum_pkg;
  localparam int DIGITS = 4;
  localparam int ADDR_W = 2;
  localparam int CODE_W = 7;
  localparam int SEG_W  = 17;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  typedef struct packed {
    logic  chr_wr;
    logic  cur_wr;
    addr_t addr;
    code_t data;
  } bus_cmd_t;

  // codes whose two top bits match have no glyph
  function automatic logic code_is_dark(code_t c);
    return c[6] == c[5];
  endfunction

  // 16-segment glyph for the 64 printable codes, indexed by code[5:0]
  // bits: 0 a1, 1 a2, 2 b, 3 c, 4 d1, 5 d2, 6 e, 7 f, 8 g1, 9 g2,
  //       10 h, 11 i, 12 j, 13 k, 14 l, 15 m
  function automatic logic [15:0] glyph16(logic [5:0] ix);
    logic [15:0] g;
    case (ix)
      6'h00: g = 16'h0AF7; 6'h01: g = 16'h03CF; 6'h02: g = 16'h4A3F; 6'h03: g = 16'h00F3;
      6'h04: g = 16'h483F; 6'h05: g = 16'h01F3; 6'h06: g = 16'h01C3; 6'h07: g = 16'h02FB;
      6'h08: g = 16'h03CC; 6'h09: g = 16'h4833; 6'h0A: g = 16'h007C; 6'h0B: g = 16'h91C0;
      6'h0C: g = 16'h00F0; 6'h0D: g = 16'h14CC; 6'h0E: g = 16'h84CC; 6'h0F: g = 16'h00FF;
      6'h10: g = 16'h03C7; 6'h11: g = 16'h80FF; 6'h12: g = 16'h83C7; 6'h13: g = 16'h03BB;
      6'h14: g = 16'h4803; 6'h15: g = 16'h00FC; 6'h16: g = 16'h30C0; 6'h17: g = 16'hA0CC;
      6'h18: g = 16'hB400; 6'h19: g = 16'h5400; 6'h1A: g = 16'h3033; 6'h1B: g = 16'h4822;
      6'h1C: g = 16'h8400; 6'h1D: g = 16'h4811; 6'h1E: g = 16'hA000; 6'h1F: g = 16'h0030;
      6'h20: g = 16'h0000; 6'h21: g = 16'h0800; 6'h22: g = 16'h0880; 6'h23: g = 16'h4B3C;
      6'h24: g = 16'h4BBB; 6'h25: g = 16'h30A9; 6'h26: g = 16'hB511; 6'h27: g = 16'h1000;
      6'h28: g = 16'h9000; 6'h29: g = 16'h2400; 6'h2A: g = 16'hFF00; 6'h2B: g = 16'h4B00;
      6'h2C: g = 16'h2000; 6'h2D: g = 16'h0300; 6'h2E: g = 16'h0010; 6'h2F: g = 16'h3000;
      6'h30: g = 16'h30FF; 6'h31: g = 16'h100C; 6'h32: g = 16'h0377; 6'h33: g = 16'h023F;
      6'h34: g = 16'h038C; 6'h35: g = 16'h03BB; 6'h36: g = 16'h03FB; 6'h37: g = 16'h000F;
      6'h38: g = 16'h03FF; 6'h39: g = 16'h03BF; 6'h3A: g = 16'h4800; 6'h3B: g = 16'h2800;
      6'h3C: g = 16'h9000; 6'h3D: g = 16'h0330; 6'h3E: g = 16'h2400; 6'h3F: g = 16'h4207;
      default: g = 16'h0000;
    endcase
    return g;
  endfunction

  // full 17-bit pattern for one character position
  function automatic seg_t render(code_t c, logic show_cursor);
    if (show_cursor)         return '1;
    else if (code_is_dark(c)) return '0;
    else                      return {1'b0, glyph16(c[5:0])};
  endfunction
endpackage

// File: rtl/alnum_bus_sync.sv
module alnum_bus_sync
  import alnum_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  code_t    data_in,
  input  addr_t    dig_addr,
  input  logic     cs1_n,
  input  logic     cs2_n,
  input  logic     wr_n,
  input  logic     store_sel,
  input  logic     cursor_on,
  input  logic     blank_n,
  input  logic     clear_n,
  output bus_cmd_t cmd,
  output logic     wr_pulse,
  output logic     cur_en_s,
  output logic     blank_act,
  output logic     clr_req
);
  localparam int RAW_W = CODE_W + ADDR_W + 7;
  localparam logic [RAW_W-1:0] IDLE =
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, {ADDR_W{1'b0}}, {CODE_W{1'b0}}};

  logic [RAW_W-1:0] raw;
  logic [RAW_W-1:0] chain [SYNC_STAGES];
  logic [RAW_W-1:0] s;
  logic             en_now, en_prev;

  assign raw = {clear_n, blank_n, cursor_on, store_sel, wr_n, cs2_n, cs1_n, dig_addr, data_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= IDLE;
    end else begin
      chain[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign s = chain[SYNC_STAGES-1];

  // combined enable: both selects and strobe low
  assign en_now = ~s[CODE_W+ADDR_W] & ~s[CODE_W+ADDR_W+1] & ~s[CODE_W+ADDR_W+2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev <= 1'b0;
    else        en_prev <= en_now;
  end

  assign wr_pulse    = en_now & ~en_prev;
  assign cmd.chr_wr  = wr_pulse &  s[CODE_W+ADDR_W+3];
  assign cmd.cur_wr  = wr_pulse & ~s[CODE_W+ADDR_W+3];
  assign cmd.addr    = s[CODE_W +: ADDR_W];
  assign cmd.data    = s[0 +: CODE_W];
  assign cur_en_s    =  s[CODE_W+ADDR_W+4];
  assign blank_act   = ~s[CODE_W+ADDR_W+5];
  assign clr_req     = ~s[CODE_W+ADDR_W+6];
endmodule

// File: rtl/alnum_scan_ctrl.sv
module alnum_scan_ctrl
  import alnum_pkg::*;
#(
  parameter int DWELL_CYCLES = 2500
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  blank_act,
  output addr_t scan_idx
);
  localparam int CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);

  logic [CNT_W-1:0] dwell_cnt;
  logic             step;

  assign step = (dwell_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell_cnt <= '0;
      scan_idx  <= '0;
    end else if (blank_act) begin
      dwell_cnt <= '0;
      scan_idx  <= '0;
    end else if (step) begin
      dwell_cnt <= '0;
      scan_idx  <= scan_idx + 1'b1;
    end else begin
      dwell_cnt <= dwell_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/alnum_char_store.sv
module alnum_char_store
  import alnum_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  bus_cmd_t                 cmd,
  input  logic                     clr_act,
  input  addr_t                    scan_idx,
  output code_t                    rd_code,
  output logic                     rd_cur,
  output logic [DIGITS*CODE_W-1:0] ascii_flat
);
  logic [DIGITS-1:0][CODE_W-1:0] words;
  logic [DIGITS-1:0]             cur_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words    <= '0;
      cur_bits <= '0;
    end else begin
      for (int k = 0; k < DIGITS; k++) begin
        if (clr_act && scan_idx == addr_t'(k))
          words[k] <= '0;
        else if (cmd.chr_wr && cmd.addr == addr_t'(k))
          words[k] <= cmd.data;
        if (cmd.cur_wr && cmd.addr == addr_t'(k))
          cur_bits[k] <= cmd.data[0];
      end
    end
  end

  assign rd_code    = words[scan_idx];
  assign rd_cur     = cur_bits[scan_idx];
  assign ascii_flat = words;
endmodule

// File: rtl/alnum_seg_drive.sv
module alnum_seg_drive
  import alnum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank_act,
  input  logic              cur_en,
  input  addr_t             scan_idx,
  input  code_t             rd_code,
  input  logic              rd_cur,
  output seg_t              seg_out,
  output logic [DIGITS-1:0] dig_en
);
  logic [DIGITS-1:0] dig_dec;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dec
    assign dig_dec[g] = (scan_idx == addr_t'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_out <= '0;
      dig_en  <= '0;
    end else if (blank_act) begin
      seg_out <= '0;
      dig_en  <= '0;
    end else begin
      seg_out <= render(rd_code, cur_en & rd_cur);
      dig_en  <= dig_dec;
    end
  end
endmodule

// File: rtl/alnum_disp_ctrl.sv
module alnum_disp_ctrl
  import alnum_pkg::*;
#(
  parameter int DWELL_CYCLES = 2500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  data_in,
  input  logic [1:0]  dig_addr,
  input  logic        cs1_n,
  input  logic        cs2_n,
  input  logic        wr_n,
  input  logic        store_sel,
  input  logic        cursor_on,
  input  logic        blank_n,
  input  logic        clear_n,
  output logic [16:0] seg_out,
  output logic [3:0]  dig_en
);
  bus_cmd_t                 cmd;
  logic                     wr_pulse, cur_en_s, blank_act, clr_req, clr_act;
  logic                     chr_wr, cur_wr;
  addr_t                    wr_addr, scan_idx;
  code_t                    wr_data, rd_code;
  logic                     rd_cur;
  logic [DIGITS*CODE_W-1:0] ascii_flat;

  alnum_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .data_in, .dig_addr, .cs1_n, .cs2_n, .wr_n, .store_sel,
    .cursor_on, .blank_n, .clear_n, .cmd, .wr_pulse, .cur_en_s, .blank_act, .clr_req
  );

  // named events for the checker
  assign chr_wr  = cmd.chr_wr;
  assign cur_wr  = cmd.cur_wr;
  assign wr_addr = cmd.addr;
  assign wr_data = cmd.data;
  assign clr_act = clr_req & ~blank_act;

  alnum_scan_ctrl #(.DWELL_CYCLES(DWELL_CYCLES)) u_scan (
    .clk, .rst_n, .blank_act, .scan_idx
  );

  alnum_char_store u_store (
    .clk, .rst_n, .cmd, .clr_act, .scan_idx, .rd_code, .rd_cur, .ascii_flat
  );

  alnum_seg_drive u_drive (
    .clk, .rst_n, .blank_act, .cur_en(cur_en_s), .scan_idx, .rd_code, .rd_cur,
    .seg_out, .dig_en
  );
endmodule

// File: rtl/alnum_disp_chk.sv
module alnum_disp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_pulse,
  input logic        chr_wr,
  input logic        cur_wr,
  input logic [1:0]  wr_addr,
  input logic [6:0]  wr_data,
  input logic        clr_act,
  input logic        blank_act,
  input logic [1:0]  scan_idx,
  input logic [27:0] ascii_flat,
  input logic [3:0]  dig_en,
  input logic [16:0] seg_out
);
  function automatic logic [6:0] word_at(logic [27:0] f, logic [1:0] a);
    return f[int'(a)*7 +: 7];
  endfunction

  logic [3:0] prev_dig;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_dig <= '0;
    else        prev_dig <= dig_en;
  end

  // R1
  chr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_wr && !clr_act) |=> word_at(ascii_flat, $past(wr_addr)) == $past(wr_data));

  // R1
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R3
  cursor_keeps_chr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_wr && !clr_act) |=> ascii_flat == $past(ascii_flat));

  // R4
  one_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig_en));

  // R4
  scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_en != 4'b0 && prev_dig != 4'b0 && dig_en != prev_dig)
      |-> dig_en == {prev_dig[2:0], prev_dig[3]});

  // R6
  dp_only_cursor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_out[16] |-> seg_out[15:0] == 16'hFFFF);

  // R8
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_act |=> (dig_en == 4'b0 && seg_out == 17'b0));

  // R10
  clear_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> word_at(ascii_flat, $past(scan_idx)) == 7'b0);

  // R11
  blank_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_act && !chr_wr) |=> ascii_flat == $past(ascii_flat));
endmodule

bind alnum_disp_ctrl alnum_disp_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .chr_wr(chr_wr), .cur_wr(cur_wr),
  .wr_addr(wr_addr), .wr_data(wr_data), .clr_act(clr_act), .blank_act(blank_act),
  .scan_idx(scan_idx), .ascii_flat(ascii_flat), .dig_en(dig_en), .seg_out(seg_out)
);

// File: tb/alnum_disp_ctrl_tb_top.sv
module alnum_disp_ctrl_tb_top;
  localparam int DW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  data_in = '0;
  logic [1:0]  dig_addr = '0;
  logic        cs1_n = 1'b1, cs2_n = 1'b1, wr_n = 1'b1;
  logic        store_sel = 1'b1, cursor_on = 1'b0, blank_n = 1'b1, clear_n = 1'b1;
  logic [16:0] seg_out;
  logic [3:0]  dig_en;

  always #5 clk = ~clk;

  alnum_disp_ctrl #(.DWELL_CYCLES(DW), .SYNC_STAGES(2)) dut_i (
    .clk, .rst_n, .data_in, .dig_addr, .cs1_n, .cs2_n, .wr_n, .store_sel,
    .cursor_on, .blank_n, .clear_n, .seg_out, .dig_en
  );

  int          n_chk = 0, n_fail = 0;
  bit          reported = 0;
  logic [6:0]  m_code [4];
  logic        m_cur  [4];
  logic [16:0] frame  [4];
  logic [3:0]  got;
  bit          multi_hot;
  logic [16:0] seen   [64];
  bit          seen_v [64];

  task automatic chk(input bit ok, input string req, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  // R6 fixed glyphs stated in the requirement
  function automatic bit known_glyph(input logic [6:0] c, output logic [16:0] v);
    case (c)
      7'h20: begin v = 17'h00000; return 1; end
      7'h30: begin v = 17'h030FF; return 1; end
      7'h38: begin v = 17'h003FF; return 1; end
      7'h2A: begin v = 17'h0FF00; return 1; end
      7'h41: begin v = 17'h003CF; return 1; end
      7'h5F: begin v = 17'h00030; return 1; end
      default: begin v = 'x; return 0; end
    endcase
  endfunction

  task automatic capture();
    got = '0; multi_hot = 0;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 4*DW + 4; c++) begin
      @(negedge clk);
      if ($countones(dig_en) > 1) multi_hot = 1;
      for (int k = 0; k < 4; k++)
        if (dig_en == (4'b1 << k)) begin frame[k] = seg_out; got[k] = 1'b1; end
    end
  endtask

  task automatic check_frame(input string tag);
    logic [16:0] kv;
    capture();
    chk(!multi_hot, {"R4 one digit ", tag}, 17'(dig_en), 17'h0);
    for (int k = 0; k < 4; k++) begin
      chk(got[k], {"R4 digit visited ", tag}, 17'(got), 17'hF);
      if (cursor_on && m_cur[k])
        chk(frame[k] == 17'h1FFFF, {"R7 cursor glyph ", tag}, frame[k], 17'h1FFFF);
      else if (m_code[k][6] == m_code[k][5])
        chk(frame[k] == 17'h0, {"R5 dark code ", tag}, frame[k], 17'h0);
      else if (known_glyph(m_code[k], kv))
        chk(frame[k] == kv, {"R6 glyph ", tag}, frame[k], kv);
      else begin
        chk(!frame[k][16] && frame[k] != 17'h0, {"R6 dp off, lit ", tag}, frame[k], 17'h0FFFF);
        if (seen_v[m_code[k][5:0]])
          chk(frame[k] == seen[m_code[k][5:0]], {"R6 stable glyph ", tag},
              frame[k], seen[m_code[k][5:0]]);
        else begin
          seen[m_code[k][5:0]] = frame[k]; seen_v[m_code[k][5:0]] = 1;
        end
      end
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [6:0] d, input bit sel,
                           input bit e1, input bit e2, input bit pulse);
    @(negedge clk);
    dig_addr = a; data_in = d; store_sel = sel; cs1_n = e1; cs2_n = e2;
    @(negedge clk); wr_n = !pulse;
    repeat (4) @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs1_n = 1'b1; cs2_n = 1'b1;
    repeat (6) @(negedge clk);
    if (!e1 && !e2 && pulse) begin
      if (sel) m_code[a] = d; else m_cur[a] = d[0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    int seed;
    for (int k = 0; k < 4; k++) begin m_code[k] = '0; m_cur[k] = 1'b0; end
    for (int i = 0; i < 64; i++) seen_v[i] = 0;
    seed = $urandom(32'h5EED_0C7A);

    // R12 reset state
    repeat (3) @(negedge clk);
    chk(seg_out == 0 && dig_en == 0, "R12 outputs in reset", seg_out, 17'h0);
    rst_n = 1'b1;
    check_frame("R12 after reset");

    // R1, R6 directed glyphs
    bus_write(2'd0, 7'h30, 1, 0, 0, 1);
    bus_write(2'd1, 7'h41, 1, 0, 0, 1);
    bus_write(2'd2, 7'h38, 1, 0, 0, 1);
    bus_write(2'd3, 7'h5F, 1, 0, 0, 1);
    check_frame("R1 directed");

    // R2 disabled strobes
    bus_write(2'd0, 7'h2A, 1, 1, 0, 1);
    bus_write(2'd0, 7'h2A, 1, 0, 1, 1);
    bus_write(2'd0, 7'h2A, 1, 0, 0, 0);
    check_frame("R2 ignored");

    // R1 data change while held active is not stored
    @(negedge clk); dig_addr = 2'd1; data_in = 7'h2A; store_sel = 1; cs1_n = 0; cs2_n = 0;
    @(negedge clk); wr_n = 0;
    repeat (6) @(negedge clk); data_in = 7'h20;
    repeat (6) @(negedge clk); wr_n = 1; cs1_n = 1; cs2_n = 1;
    m_code[1] = 7'h2A;
    check_frame("R1 single commit");

    // R3, R7 cursor overlay
    bus_write(2'd2, 7'h01, 0, 0, 0, 1);
    cursor_on = 1'b0;
    check_frame("R7 cursor hidden");
    cursor_on = 1'b1;
    check_frame("R7 cursor shown");
    bus_write(2'd2, 7'h7E, 0, 0, 0, 1);
    check_frame("R3 cursor removed");
    cursor_on = 1'b0;

    // R5 dark codes
    bus_write(2'd0, 7'h00, 1, 0, 0, 1);
    bus_write(2'd1, 7'h7F, 1, 0, 0, 1);
    bus_write(2'd2, 7'h65, 1, 0, 0, 1);
    bus_write(2'd3, 7'h1A, 1, 0, 0, 1);
    check_frame("R5 dark");
    bus_write(2'd0, 7'h30, 1, 0, 0, 1);
    bus_write(2'd1, 7'h38, 1, 0, 0, 1);

    // R8 blank darkens, writes still accepted
    @(negedge clk); blank_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(seg_out == 0 && dig_en == 0, "R8 blank dark", {dig_en, seg_out[12:0]}, 17'h0);
    end
    bus_write(2'd2, 7'h41, 1, 0, 0, 1);
    // R9 scan restart at digit 0
    @(negedge clk); blank_n = 1'b1;
    begin
      logic [3:0] first = '0;
      for (int c = 0; c < 20 && first == 0; c++) begin
        @(negedge clk); first = dig_en;
      end
      chk(first == 4'b0001, "R9 first digit", 17'(first), 17'h1);
    end
    check_frame("R8 write during blank");

    // R11 clear inhibited by blank
    @(negedge clk); blank_n = 1'b0;
    repeat (3) @(negedge clk); clear_n = 1'b0;
    repeat (6*DW) @(negedge clk); clear_n = 1'b1;
    repeat (3) @(negedge clk); blank_n = 1'b1;
    check_frame("R11 clear under blank");

    // R10 full clear with selects low and a cursor write during it
    @(negedge clk); clear_n = 1'b0; cs1_n = 0; cs2_n = 0;
    dig_addr = 2'd3; data_in = 7'h01; store_sel = 0;
    repeat (3) @(negedge clk); wr_n = 0;
    repeat (4) @(negedge clk); wr_n = 1;
    repeat (4*DW + 8) @(negedge clk);
    clear_n = 1'b1; cs1_n = 1; cs2_n = 1; store_sel = 1;
    for (int k = 0; k < 4; k++) m_code[k] = '0;
    m_cur[3] = 1'b1;
    check_frame("R10 cleared");
    cursor_on = 1'b1;
    check_frame("R10 cursor kept");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int r  = $urandom % 8;
      bit sl = ($urandom % 4) != 0;
      bus_write(2'($urandom % 4), 7'($urandom % 128), sl, r == 0, r == 1, 1);
      cursor_on = ($urandom % 3) == 0;
      if (it % 3 == 2) check_frame("R1 random");
    end
    check_frame("R7 random end");

    report();
    $finish;
  end
endmodule